// File: doc/BRIEF.md
# Windowed Memory Bank Mapper

This block places a 16-bit CPU address space over a larger banked memory. The CPU space is cut into four equal windows of 16 KB. The top two address bits pick a window and the remaining fourteen bits give the offset inside it. Each window is steered either to one 16 KB block of a 32-block RAM or to one of two fixed ROM images. An 8-bit configuration register holds the steering. The CPU loads it through a one-cycle write strobe.

The configuration can force every window onto the first ROM, which is the state after system reset. Otherwise it chooses a group of four consecutive RAM blocks. It can also mirror the upper window pair onto the lower pair, and it can overlay the second ROM on the top window. Each window reports an 8-bit identifier, and an identifier of 0xF0 or above marks that window as read-only. A CPU write that lands on a read-only window changes no storage. The block drives the physical RAM address of the current access. The RAM cells and the ROM contents sit inside the block. Only the low `STORE_W` offset bits of each RAM block have real cells.

Top module: `winbank_mapper`

## Requirements
- R1: For an access to a RAM window, `ram_paddr` equals {block number, cpu_addr[13:0]}, and cpu_addr[15:14] selects the window. For an access to a ROM window, `ram_paddr` is zero.
- R2: After reset, every RAM cell reads 0x3F.
- R3: The configuration register resets to 0x20. While bit 5 is set, all four window identifiers are 0xF0 (ROM0) and every other configuration bit is ignored.
- R4: With bit 5 clear, window w maps to RAM block 4*cfg[3:1] + w, and its identifier is that block number (0x00 to 0x1F).
- R5: With bit 5 clear and bit 0 set, window 0 takes the block of window 2 and window 1 takes the block of window 3.
- R6: With bits 5 and 4 both clear, window 3 carries identifier 0xF1 (ROM1). This overlay applies after the mirroring of R5.
- R7: Let mon(i) = i[7:0] XOR {000,i[12:8]} and ldr(i) = i[7:0] + {000,i[12:8]} + 0x80, modulo 256. ROM0 reads mon(off[12:0]) at every offset. ROM1 reads ldr(off[12:0]) when off[13] is 0 and mon(off[12:0]) when off[13] is 1.
- R8: A CPU write to a window whose identifier is 0xF0 or above leaves every RAM cell unchanged.
- R9: A CPU write to a RAM window commits on the clock edge. Cell index is {block, off[STORE_W-1:0]}, so offsets that differ only above bit STORE_W-1 alias.
- R10: A configuration write takes effect on the clock edge where `cfg_we` is high. `win_ids` carries window w in bits [8w+7:8w] and changes only after a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration value |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | CPU write enable |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| ram_paddr | output | 19 | Physical RAM address of current access |
| win_ids | output | 32 | Identifier of each window, window 0 lowest |

## Verification
The bench sweeps all 256 configuration values twice: once over freshly reset RAM and once after the RAM holds distinct written patterns. The second pass catches a mapper that mirrors the wrong pair, applies the ROM overlay before the mirror, or ignores the reset flag. Any of these faults would return data from the wrong block. It writes to ROM-mapped windows under both the reset flag and the top-window overlay, then reveals the RAM block underneath. A design that let the write through would show the new byte there. Writes at offsets above the stored depth check aliasing. A check at the cycle of the configuration strobe catches a register that is transparent instead of edge-loaded.

// File: rtl/winbank_pkg.sv
package winbank_pkg;
   localparam logic [7:0] ID_ROM0    = 8'hF0;
   localparam logic [7:0] ID_ROM1    = 8'hF1;
   localparam logic [7:0] RO_FLOOR   = 8'hF0;
   localparam logic [7:0] CFG_RESET  = 8'h20;
   localparam logic [7:0] RAM_INIT   = 8'h3F;
   localparam int         CFG_MIRROR = 0;
   localparam int         CFG_ROMOFF = 4;
   localparam int         CFG_HOLD   = 5;

   // Monitor image byte at image offset i
   function automatic logic [7:0] monitor_byte(input logic [12:0] i);
      return i[7:0] ^ {3'b000, i[12:8]};
   endfunction

   // Loader image byte at image offset i
   function automatic logic [7:0] loader_byte(input logic [12:0] i);
      return i[7:0] + {3'b000, i[12:8]} + 8'h80;
   endfunction
endpackage

// File: rtl/winbank_cfg_reg.sv
module winbank_cfg_reg
   import winbank_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   output logic [7:0] cfg_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= CFG_RESET;
      else if (we) cfg_q <= wdata;
   end
endmodule

// File: rtl/winbank_window_map.sv
module winbank_window_map
   import winbank_pkg::*;
#(
   parameter int NUM_WIN = 4,
   parameter int BLK_W   = 5,
   localparam int SEL_W  = $clog2(NUM_WIN)
) (
   input  logic [7:0]           cfg,
   output logic [NUM_WIN*8-1:0] ids
);
   if (BLK_W < 3 + SEL_W || BLK_W > 7) begin : g_bad_blk
      $error("winbank_window_map: BLK_W out of range");
   end
   if (NUM_WIN != 2 ** SEL_W || NUM_WIN < 2) begin : g_bad_win
      $error("winbank_window_map: NUM_WIN must be a power of two");
   end

   logic [BLK_W-1:0] base_blk;
   logic             unused_cfg_hi;
   assign base_blk      = BLK_W'({cfg[3:1], {SEL_W{1'b0}}});
   assign unused_cfg_hi = ^cfg[7:6];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam int MIR_SRC = (w < NUM_WIN / 2) ? w + NUM_WIN / 2 : w;
      logic [BLK_W-1:0] blk;
      assign blk = base_blk + BLK_W'(cfg[CFG_MIRROR] ? MIR_SRC : w);
      if (w == NUM_WIN - 1) begin : g_top
         assign ids[w*8 +: 8] = cfg[CFG_HOLD]    ? ID_ROM0 :
                                !cfg[CFG_ROMOFF] ? ID_ROM1 : 8'(blk);
      end else begin : g_low
         assign ids[w*8 +: 8] = cfg[CFG_HOLD] ? ID_ROM0 : 8'(blk);
      end
   end
endmodule

// File: rtl/winbank_rom.sv
module winbank_rom
   import winbank_pkg::*;
#(
   parameter int OFF_W = 14
) (
   input  logic [OFF_W-1:0] off,
   input  logic             sel_loader,
   output logic [7:0]       rdata
);
   if (OFF_W < 2) begin : g_bad_off
      $error("winbank_rom: OFF_W too small");
   end
   logic [12:0] img_off;
   assign img_off = 13'(off[OFF_W-2:0]);
   assign rdata   = (sel_loader && !off[OFF_W-1]) ? loader_byte(img_off)
                                                  : monitor_byte(img_off);
endmodule

// File: rtl/winbank_ram.sv
module winbank_ram
   import winbank_pkg::*;
#(
   parameter int BLK_W   = 5,
   parameter int STORE_W = 6,
   localparam int IDX_W  = BLK_W + STORE_W,
   localparam int DEPTH  = 2 ** IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata
);
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= RAM_INIT;
      end else if (we) begin
         cells[idx] <= wdata;
      end
   end

   assign rdata = cells[idx];
endmodule

// File: rtl/winbank_mapper.sv
module winbank_mapper
   import winbank_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int WIN_SEL_W = 2,
   parameter int BLK_W     = 5,
   parameter int STORE_W   = 6,
   localparam int NUM_WIN  = 2 ** WIN_SEL_W,
   localparam int OFF_W    = ADDR_W - WIN_SEL_W,
   localparam int PADDR_W  = BLK_W + OFF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [7:0]           cfg_wdata,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic                 cpu_we,
   input  logic [7:0]           cpu_wdata,
   output logic [7:0]           cpu_rdata,
   output logic [PADDR_W-1:0]   ram_paddr,
   output logic [NUM_WIN*8-1:0] win_ids
);
   if (STORE_W < 1 || STORE_W > OFF_W) begin : g_bad_store
      $error("winbank_mapper: STORE_W must lie in 1..OFF_W");
   end

   logic [7:0]           cfg_q;
   logic [WIN_SEL_W-1:0] win_sel;
   logic [OFF_W-1:0]     win_off;
   logic [7:0]           cur_id;
   logic                 cur_ro;
   logic [7:0]           rom_data;
   logic [7:0]           ram_data;

   winbank_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg_q (cfg_q)
   );

   winbank_window_map #(.NUM_WIN(NUM_WIN), .BLK_W(BLK_W)) u_map (
      .cfg (cfg_q),
      .ids (win_ids)
   );

   assign win_sel = cpu_addr[ADDR_W-1 -: WIN_SEL_W];
   assign win_off = cpu_addr[OFF_W-1:0];
   assign cur_id  = win_ids[{win_sel, 3'b000} +: 8];
   assign cur_ro  = (cur_id >= RO_FLOOR);

   winbank_rom #(.OFF_W(OFF_W)) u_rom (
      .off        (win_off),
      .sel_loader (cur_id == ID_ROM1),
      .rdata      (rom_data)
   );

   winbank_ram #(.BLK_W(BLK_W), .STORE_W(STORE_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cpu_we && !cur_ro),
      .idx   ({cur_id[BLK_W-1:0], win_off[STORE_W-1:0]}),
      .wdata (cpu_wdata),
      .rdata (ram_data)
   );

   assign cpu_rdata = cur_ro ? rom_data : ram_data;
   assign ram_paddr = cur_ro ? '0 : {cur_id[BLK_W-1:0], win_off};
endmodule

// File: rtl/winbank_mapper_chk.sv
module winbank_mapper_chk
   import winbank_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int WIN_SEL_W = 2,
   parameter int BLK_W     = 5,
   parameter int STORE_W   = 6,
   localparam int NUM_WIN  = 2 ** WIN_SEL_W,
   localparam int OFF_W    = ADDR_W - WIN_SEL_W,
   localparam int PADDR_W  = BLK_W + OFF_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we,
   input logic [7:0]           cfg_wdata,
   input logic [ADDR_W-1:0]    cpu_addr,
   input logic                 cpu_we,
   input logic [7:0]           cpu_wdata,
   input logic [7:0]           cpu_rdata,
   input logic [PADDR_W-1:0]   ram_paddr,
   input logic [NUM_WIN*8-1:0] win_ids
);
   logic [7:0] seen_id;
   logic       seen_ro;
   assign seen_id = win_ids[{cpu_addr[ADDR_W-1 -: WIN_SEL_W], 3'b000} +: 8];
   assign seen_ro = seen_id >= RO_FLOOR;

   AST_PADDR_ROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      seen_ro |-> ram_paddr == '0); // R1
   AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_ro |-> ram_paddr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]); // R1
   AST_HOLD_FLAG_ALL_ROM0: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_wdata[CFG_HOLD]) |=> win_ids == {NUM_WIN{ID_ROM0}}); // R3
   AST_ROM0_NEVER_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (win_ids[7:0] == ID_ROM0) |-> win_ids == {NUM_WIN{ID_ROM0}}); // R3
   AST_MIRROR_LOW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_wdata[CFG_HOLD] && cfg_wdata[CFG_MIRROR])
      |=> win_ids[7:0] == win_ids[(NUM_WIN/2)*8 +: 8]); // R5
   AST_TOP_OVERLAY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_wdata[CFG_HOLD] && !cfg_wdata[CFG_ROMOFF])
      |=> win_ids[NUM_WIN*8-1 -: 8] == ID_ROM1); // R6
   AST_ROM_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && seen_ro && !cfg_we) |=> ($stable(cpu_addr) -> $stable(cpu_rdata))); // R8
   AST_RAM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && !seen_ro && !cfg_we) |=> ($stable(cpu_addr) -> cpu_rdata == $past(cpu_wdata))); // R9
   AST_IDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(win_ids)); // R10
endmodule

bind winbank_mapper winbank_mapper_chk #(
   .ADDR_W(ADDR_W), .WIN_SEL_W(WIN_SEL_W), .BLK_W(BLK_W), .STORE_W(STORE_W)
) u_chk (.*);

// File: tb/winbank_mapper_bench.sv
module winbank_mapper_bench;
   localparam int CLK_PERIOD = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_we = 1'b0;
   logic [7:0]  cpu_wdata = 8'h00;
   logic [7:0]  cpu_rdata;
   logic [18:0] ram_paddr;
   logic [31:0] win_ids;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [7:0] shadow [2048];
   logic [7:0] cur_cfg = 8'h20;

   always #(CLK_PERIOD/2) clk = ~clk;

   winbank_mapper u_winbank_mapper (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .ram_paddr(ram_paddr), .win_ids(win_ids)
   );

   function automatic logic [7:0] f_mon(input logic [12:0] i);
      return i[7:0] ^ {3'b000, i[12:8]};
   endfunction
   function automatic logic [7:0] f_ldr(input logic [12:0] i);
      return i[7:0] + {3'b000, i[12:8]} + 8'h80;
   endfunction

   function automatic logic [7:0] exp_id(input logic [7:0] c, input int w);
      int blk;
      if (c[5]) return 8'hF0;
      if (w == 3 && !c[4]) return 8'hF1;
      blk = c[3:1] * 4 + ((c[0] && w < 2) ? w + 2 : w);
      return 8'(blk);
   endfunction

   function automatic logic [31:0] exp_ids(input logic [7:0] c);
      return {exp_id(c, 3), exp_id(c, 2), exp_id(c, 1), exp_id(c, 0)};
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] c, input logic [15:0] a);
      logic [7:0] id;
      id = exp_id(c, int'(a[15:14]));
      if (id == 8'hF0) return f_mon(a[12:0]);
      if (id == 8'hF1) return a[13] ? f_mon(a[12:0]) : f_ldr(a[12:0]);
      return shadow[{id[4:0], a[5:0]}];
   endfunction

   function automatic logic [18:0] exp_paddr(input logic [7:0] c, input logic [15:0] a);
      logic [7:0] id;
      id = exp_id(c, int'(a[15:14]));
      if (id >= 8'hF0) return '0;
      return {id[4:0], a[13:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      cur_cfg = v;
   endtask

   task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
      logic [7:0] id;
      @(negedge clk);
      cpu_addr = a;
      cpu_we = 1'b1;
      cpu_wdata = d;
      @(negedge clk);
      cpu_we = 1'b0;
      id = exp_id(cur_cfg, int'(a[15:14]));
      if (id < 8'hF0) shadow[{id[4:0], a[5:0]}] = d;
   endtask

   task automatic read_chk(input string req, input logic [15:0] a);
      @(negedge clk);
      cpu_addr = a;
      #2;
      chk(req, 32'(cpu_rdata), 32'(exp_read(cur_cfg, a)));
   endtask

   task automatic sweep(input string tag);
      for (int c = 0; c < 256; c++) begin
         cfg_write(8'(c));
         #2;
         chk({tag, " R3/R4/R5/R6 ids"}, win_ids, exp_ids(8'(c)));
         for (int w = 0; w < 4; w++) begin
            logic [15:0] a;
            a = {2'(w), 14'((c * 37 + w * 1111 + 16'(tag.len()) * 4099) & 16'h3FFF)};
            read_chk({tag, " R2/R7/R9 read"}, a);
            chk({tag, " R1 paddr"}, 32'(ram_paddr), 32'(exp_paddr(8'(c), a)));
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) shadow[i] = 8'h3F;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R3 reset ids", win_ids, 32'hF0F0F0F0);
      read_chk("R7 reset rom0 low half", 16'h0123);
      read_chk("R7 reset rom0 upper half", 16'hF1A5);

      // R10: config strobe is edge-loaded
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = 8'h12;
      #2;
      chk("R10 ids before edge", win_ids, 32'hF0F0F0F0);
      @(negedge clk);
      cfg_we = 1'b0;
      cur_cfg = 8'h12;
      #2;
      chk("R10 ids after edge", win_ids, 32'h07060504);

      sweep("fresh");

      // RAM writes, including aliasing above the stored offset bits (R9)
      for (int k = 0; k < 8; k++) begin
         cfg_write(8'h10 | 8'(k << 1));
         for (int w = 0; w < 4; w++) begin
            for (int j = 0; j < 3; j++) begin
               logic [15:0] a;
               a = {2'(w), 14'(j * 16'h1000 + ((j * 17 + k * 5 + w * 3) & 63))};
               mem_write(a, 8'(k * 16 + w * 4 + j) ^ 8'h5A);
               read_chk("R9 write readback", a);
            end
            read_chk("R9 alias", {2'(w), 14'h2000 | 14'((2 * 17 + k * 5 + w * 3) & 63)});
         end
      end

      // R8: write under top-window ROM overlay
      cfg_write(8'h02);
      mem_write(16'hC005, 8'h77);
      read_chk("R8 rom1 after write", 16'hC005);
      cfg_write(8'h12);
      read_chk("R8 ram under rom1 untouched", 16'hC005);
      // R8: write while hold flag maps all to ROM0
      cfg_write(8'h20);
      mem_write(16'h4003, 8'h99);
      read_chk("R8 rom0 after write", 16'h4003);
      cfg_write(8'h10);
      read_chk("R8 ram under rom0 untouched", 16'h4003);

      sweep("filled");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule